// File: doc/BRIEF.md
# Prioritized Transmit Buffer Manager

This block tracks a small set of transmit message slots for a frame controller. Each slot carries a 4-bit state code. All the state codes are packed into one status word. Each slot also has a 3-bit priority, and all the priorities are packed into one priority word. Software-style commands arrive as a write with a slot bit mask and three command flags: abort, set-ready and set-empty. Each selected slot then moves through its own small state machine.

An arbiter looks at every slot that is waiting to be sent. It offers the best one to the transmitter over a valid/ready handshake. Once the transmitter accepts a slot, that slot is locked in a busy state until the transmitter reports success or failure. Success marks the slot as sent, advances a wrapping frame counter and pulses two event outputs. A not-full flag tells the producer whether any slot is free to be filled.

Top module: `txbuf_mgr`

## Requirements
- R1: After reset every slot is empty, `tx_valid` is 0, `tx_count` is 0, `not_full` is 1 and both event outputs are 0.
- R2: Slot i reports its state in `buf_status[4i+3:4i]` with the codes empty=0, ready=1, sent=2, error=3, aborted=4 and busy=5. It takes its priority from `prio_wdata[4i+2:4i]` when `prio_we` is 1, and reports it in the same bits of `prio_word`, where bit 4i+3 reads 0. Command mask bit `cmd_sel[i]` selects slot i.
- R3: An abort moves a selected slot from ready to aborted. A selected slot in any other state keeps its state.
- R4: A set-ready moves a selected slot to ready from empty, sent, error or aborted. A busy slot keeps its state.
- R5: A set-empty moves a selected slot to empty from sent, error or aborted. A ready, busy or empty slot keeps its state.
- R6: When several command flags arrive in one write, each selected slot applies abort first, then set-ready, then set-empty, and each step sees the result of the step before.
- R7: While `ctrl_en` is 0, commands change no slot and `tx_valid` stays 0.
- R8: `tx_valid` offers, in `tx_idx`, the ready slot with the highest priority. On a tie the lowest index wins. A ready slot with priority 0 is never offered.
- R9: On `tx_valid && tx_ready` the offered slot becomes busy. No offer is made until the transmitter reports the result. A transmitter result and the accept take effect before any command in the same cycle.
- R10: `tx_done` while a slot is busy moves it to sent. In the next cycle `tx_count` is one higher, wrapping at its width, and `ev_tx` and `ev_buf_chg` pulse for one cycle. `tx_err` without `tx_done` moves the busy slot to error without counting. Both inputs are ignored when no slot is busy.
- R11: `not_full` is 1 exactly when at least one slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; gates commands and offers |
| cmd_valid | input | 1 | Command write strobe |
| cmd_abort | input | 1 | Abort flag |
| cmd_set_ready | input | 1 | Set-ready flag |
| cmd_set_empty | input | 1 | Set-empty flag |
| cmd_sel | input | NBUF | Slot select mask |
| prio_we | input | 1 | Priority word write strobe |
| prio_wdata | input | 4*NBUF | Priority word write data |
| buf_status | output | 4*NBUF | Packed slot state codes |
| prio_word | output | 4*NBUF | Packed slot priorities |
| tx_valid | output | 1 | A slot is offered to the transmitter |
| tx_idx | output | clog2(NBUF) | Index of the offered slot |
| tx_ready | input | 1 | Transmitter accepts the offer |
| tx_done | input | 1 | Transmitter reports success |
| tx_err | input | 1 | Transmitter reports failure |
| not_full | output | 1 | At least one slot is empty |
| tx_count | output | CNT_W | Wrapping count of frames sent |
| ev_tx | output | 1 | Frame-sent event pulse |
| ev_buf_chg | output | 1 | Slot-changed event pulse |

## Verification
The bench builds the block with four slots and a 3-bit priority. This gives ties, priority-0 slots and slots of every state at once, with room to command them all in one mask. The frame counter is narrowed to 4 bits so that random traffic of a few thousand cycles wraps it several times. Random command flags in every combination, together with random accept, success and failure timing, reach the same-cycle case where a result and a command hit the same slot.

// File: rtl/txbm_pkg.sv
package txbm_pkg;

  localparam int FIELD_W = 4;

  typedef enum logic [FIELD_W-1:0] {
    ST_EMPTY = 4'd0,
    ST_READY = 4'd1,
    ST_SENT  = 4'd2,
    ST_ERROR = 4'd3,
    ST_ABORT = 4'd4,
    ST_BUSY  = 4'd5
  } slot_st_e;

  // Ordered command application: abort, then set-ready, then set-empty.
  function automatic slot_st_e apply_cmds(slot_st_e s, logic ab, logic rd, logic em);
    slot_st_e r;
    r = s;
    if (ab && r == ST_READY) r = ST_ABORT;
    if (rd && (r == ST_EMPTY || r == ST_SENT || r == ST_ERROR || r == ST_ABORT)) r = ST_READY;
    if (em && (r == ST_SENT || r == ST_ERROR || r == ST_ABORT)) r = ST_EMPTY;
    return r;
  endfunction

endpackage

// File: rtl/txbm_slot.sv
module txbm_slot
  import txbm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_hit,
  input  logic     cmd_abort,
  input  logic     cmd_set_ready,
  input  logic     cmd_set_empty,
  input  logic     take,
  input  logic     fin_ok,
  input  logic     fin_err,
  output slot_st_e st
);

  slot_st_e after_tx;
  slot_st_e st_nxt;

  // Transmitter events resolve first, commands see their result.
  always_comb begin
    after_tx = st;
    if (take)         after_tx = ST_BUSY;
    if (fin_ok)       after_tx = ST_SENT;
    else if (fin_err) after_tx = ST_ERROR;
    st_nxt = cmd_hit ? apply_cmds(after_tx, cmd_abort, cmd_set_ready, cmd_set_empty)
                     : after_tx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_EMPTY;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/txbm_arbiter.sv
module txbm_arbiter
  import txbm_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int PW   = 3,
  localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  slot_st_e          st [NBUF],
  input  logic [NBUF*PW-1:0] prio,
  output logic              found,
  output logic [IW-1:0]     pick
);

  logic [PW-1:0] best;

  // Strict greater-than keeps the lowest index on ties; best starts at 0,
  // so a priority-0 slot can never win.
  always_comb begin
    best = '0;
    pick = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (st[i] == ST_READY && prio[i*PW +: PW] > best) begin
        best = prio[i*PW +: PW];
        pick = IW'(i);
      end
    end
    found = (best != '0);
  end

endmodule

// File: rtl/txbuf_mgr.sv
module txbuf_mgr
  import txbm_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int PW    = 3,
  parameter int CNT_W = 16,
  localparam int IW   = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int SW   = FIELD_W * NBUF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             cmd_valid,
  input  logic             cmd_abort,
  input  logic             cmd_set_ready,
  input  logic             cmd_set_empty,
  input  logic [NBUF-1:0]  cmd_sel,
  input  logic             prio_we,
  input  logic [SW-1:0]    prio_wdata,
  output logic [SW-1:0]    buf_status,
  output logic [SW-1:0]    prio_word,
  output logic             tx_valid,
  output logic [IW-1:0]    tx_idx,
  input  logic             tx_ready,
  input  logic             tx_done,
  input  logic             tx_err,
  output logic             not_full,
  output logic [CNT_W-1:0] tx_count,
  output logic             ev_tx,
  output logic             ev_buf_chg
);

  slot_st_e         st [NBUF];
  logic [NBUF*PW-1:0] prio_q;
  logic             found;
  logic             busy_q;
  logic [IW-1:0]    act_q;

  // Named internal events, visible to the checker.
  logic cmd_go;
  logic accept;
  logic done_ok;
  logic err_hit;

  assign cmd_go  = ctrl_en & cmd_valid;
  assign accept  = tx_valid & tx_ready;
  assign done_ok = busy_q & tx_done;
  assign err_hit = busy_q & tx_err & ~tx_done;

  txbm_arbiter #(.NBUF(NBUF), .PW(PW)) u_arb (
    .st    (st),
    .prio  (prio_q),
    .found (found),
    .pick  (tx_idx)
  );

  assign tx_valid = ctrl_en & ~busy_q & found;

  logic [NBUF-1:0] empty_vec;

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    txbm_slot u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_hit       (cmd_go & cmd_sel[i]),
      .cmd_abort     (cmd_abort),
      .cmd_set_ready (cmd_set_ready),
      .cmd_set_empty (cmd_set_empty),
      .take          (accept && tx_idx == IW'(i)),
      .fin_ok        (done_ok && act_q == IW'(i)),
      .fin_err       (err_hit && act_q == IW'(i)),
      .st            (st[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)       prio_q[i*PW +: PW] <= '0;
      else if (prio_we) prio_q[i*PW +: PW] <= prio_wdata[i*FIELD_W +: PW];
    end

    assign buf_status[i*FIELD_W +: FIELD_W] = st[i];
    assign prio_word[i*FIELD_W +: FIELD_W]  = FIELD_W'(prio_q[i*PW +: PW]);
    assign empty_vec[i] = (st[i] == ST_EMPTY);
  end

  assign not_full = |empty_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      act_q      <= '0;
      tx_count   <= '0;
      ev_tx      <= 1'b0;
      ev_buf_chg <= 1'b0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        act_q  <= tx_idx;
      end else if (done_ok || err_hit) begin
        busy_q <= 1'b0;
      end
      if (done_ok) tx_count <= tx_count + 1'b1;
      ev_tx      <= done_ok;
      ev_buf_chg <= done_ok;
    end
  end

endmodule

// File: rtl/txbm_chk.sv
module txbm_chk #(
  parameter int NBUF  = 4,
  parameter int CNT_W = 16,
  localparam int IW   = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int SW   = 4 * NBUF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic             tx_valid,
  input logic [IW-1:0]    tx_idx,
  input logic [SW-1:0]    buf_status,
  input logic             busy_q,
  input logic             accept,
  input logic             done_ok,
  input logic [CNT_W-1:0] tx_count,
  input logic             ev_tx,
  input logic             ev_buf_chg
);

  // R8
  offer_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> buf_status[tx_idx*4 +: 4] == 4'd1);

  // R9
  accept_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q && buf_status[$past(tx_idx)*4 +: 4] == 4'd5 && !tx_valid);

  // R10
  done_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> ev_tx && ev_buf_chg && tx_count == $past(tx_count) + CNT_W'(1));

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !busy_q) |=> $stable(buf_status));

  // R7
  disabled_no_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !tx_valid);

endmodule

bind txbuf_mgr txbm_chk #(.NBUF(NBUF), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_en    (ctrl_en),
  .tx_valid   (tx_valid),
  .tx_idx     (tx_idx),
  .buf_status (buf_status),
  .busy_q     (busy_q),
  .accept     (accept),
  .done_ok    (done_ok),
  .tx_count   (tx_count),
  .ev_tx      (ev_tx),
  .ev_buf_chg (ev_buf_chg)
);

// File: tb/txbuf_mgr_bench.sv
module txbuf_mgr_bench;

  localparam int NB = 4;
  localparam int PW = 3;
  localparam int CW = 4;
  localparam int IW = 2;
  localparam int SW = 4 * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_en = 1'b0, cmd_valid = 1'b0, cmd_abort = 1'b0;
  logic cmd_set_ready = 1'b0, cmd_set_empty = 1'b0;
  logic [NB-1:0] cmd_sel = '0;
  logic prio_we = 1'b0;
  logic [SW-1:0] prio_wdata = '0;
  logic tx_ready = 1'b0, tx_done = 1'b0, tx_err = 1'b0;
  logic [SW-1:0] buf_status, prio_word;
  logic tx_valid, not_full, ev_tx, ev_buf_chg;
  logic [IW-1:0] tx_idx;
  logic [CW-1:0] tx_count;

  always #5 clk = ~clk;

  txbuf_mgr #(.NBUF(NB), .PW(PW), .CNT_W(CW)) u_txbuf_mgr (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cmd_valid(cmd_valid),
    .cmd_abort(cmd_abort), .cmd_set_ready(cmd_set_ready),
    .cmd_set_empty(cmd_set_empty), .cmd_sel(cmd_sel), .prio_we(prio_we),
    .prio_wdata(prio_wdata), .buf_status(buf_status), .prio_word(prio_word),
    .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_ready(tx_ready),
    .tx_done(tx_done), .tx_err(tx_err), .not_full(not_full),
    .tx_count(tx_count), .ev_tx(ev_tx), .ev_buf_chg(ev_buf_chg)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference model state: plain integers.
  int m_st [NB];
  int m_pr [NB];
  int m_busy, m_act, m_cnt, m_ev;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] pack_st();
    logic [SW-1:0] w = '0;
    for (int i = 0; i < NB; i++) w[4*i +: 4] = 4'(m_st[i]);
    return w;
  endfunction

  function automatic logic [SW-1:0] pack_pr();
    logic [SW-1:0] w = '0;
    for (int i = 0; i < NB; i++) w[4*i +: 4] = 4'(m_pr[i]);
    return w;
  endfunction

  function automatic bit any_empty();
    for (int i = 0; i < NB; i++) if (m_st[i] == 0) return 1;
    return 0;
  endfunction

  // Registered outputs compared after the edge.
  task automatic cmp_regs();
    check(buf_status == pack_st(), "R2 status", buf_status, pack_st());
    check(prio_word == pack_pr(), "R2 priority", prio_word, pack_pr());
    check(tx_count == CW'(m_cnt), "R10 count", tx_count, m_cnt);
    check(ev_tx == m_ev[0], "R10 ev_tx", ev_tx, m_ev);
    check(ev_buf_chg == m_ev[0], "R10 ev_buf_chg", ev_buf_chg, m_ev);
    check(not_full == any_empty(), "R11 not_full", not_full, any_empty());
  endtask

  // One clock: drive, check offer, advance model, check registers.
  task automatic step(bit en, bit cv, bit ab, bit rd, bit em, int sel,
                      bit pwe, int pdata, bit rdy, bit dn, bit er);
    int best, pick, mv, acc, fin_ok, fin_er;
    ctrl_en = en; cmd_valid = cv; cmd_abort = ab; cmd_set_ready = rd;
    cmd_set_empty = em; cmd_sel = NB'(sel); prio_we = pwe;
    prio_wdata = SW'(pdata); tx_ready = rdy; tx_done = dn; tx_err = er;
    #1;
    best = 0; pick = 0;
    for (int i = 0; i < NB; i++)
      if (m_st[i] == 1 && m_pr[i] > best) begin best = m_pr[i]; pick = i; end
    mv = (en && !m_busy && best > 0);
    check(tx_valid == mv[0], "R8 tx_valid", tx_valid, mv);
    if (mv) check(tx_idx == IW'(pick), "R8 tx_idx", tx_idx, pick);
    acc = mv && rdy;
    fin_ok = m_busy && dn;
    fin_er = m_busy && er && !dn;
    for (int i = 0; i < NB; i++) begin
      int s = m_st[i];
      if (acc && i == pick) s = 5;
      if (fin_ok && i == m_act) s = 2;
      else if (fin_er && i == m_act) s = 3;
      if (en && cv && sel[i]) begin
        if (ab && s == 1) s = 4;
        if (rd && (s == 0 || s == 2 || s == 3 || s == 4)) s = 1;
        if (em && (s == 2 || s == 3 || s == 4)) s = 0;
      end
      m_st[i] = s;
      if (pwe) m_pr[i] = (pdata >> (4*i)) & 7;
    end
    if (acc) begin m_busy = 1; m_act = pick; end
    else if (fin_ok || fin_er) m_busy = 0;
    if (fin_ok) m_cnt = (m_cnt + 1) % (1 << CW);
    m_ev = fin_ok;
    @(posedge clk);
    @(negedge clk);
    cmp_regs();
  endtask

  task automatic idle(bit en);
    step(en, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_pr[i] = 0; end
    m_busy = 0; m_act = 0; m_cnt = 0; m_ev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(buf_status == '0, "R1 status", buf_status, 0);
    check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    check(tx_count == '0, "R1 count", tx_count, 0);
    check(not_full == 1'b1, "R1 not_full", not_full, 1);
    check(ev_tx == 1'b0 && ev_buf_chg == 1'b0, "R1 events", {ev_tx, ev_buf_chg}, 0);

    // R2: priorities slot0=2, slot1=5, slot2=5, slot3=0 (bit 3 of each nibble dropped)
    step(1, 0, 0, 0, 0, 0, 1, 'h8552, 0, 0, 0);
    // R4: all to ready; R11 not_full falls
    step(1, 1, 0, 1, 0, 'hF, 0, 0, 0, 0, 0);
    // R8: tie 5/5 offers slot 1, slot 3 with priority 0 never
    idle(1);
    check(tx_idx == 2'd1, "R8 tie lowest", tx_idx, 1);
    // R9: accept slot 1
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R3: abort busy slot 1 (no effect) and ready slot 0
    step(1, 1, 1, 0, 0, 'h3, 0, 0, 1, 0, 0);
    check(buf_status[7:4] == 4'd5, "R3 busy kept", buf_status[7:4], 5);
    // R10: success
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle(1);
    // R9: slot 2 accepted then fails
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R10: result with nothing busy is ignored
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R7: disabled commands ignored
    step(0, 1, 0, 0, 1, 'hF, 0, 0, 1, 0, 0);
    check(tx_valid == 1'b0, "R7 no offer", tx_valid, 0);
    // R6: all three flags at once, then abort+empty
    step(1, 1, 1, 1, 1, 'hF, 0, 0, 0, 0, 0);
    check(buf_status == 16'h1111, "R6 ordered", buf_status, 'h1111);
    step(1, 1, 1, 0, 1, 'hF, 0, 0, 0, 0, 0);
    check(buf_status == 16'h0000, "R5 emptied", buf_status, 0);

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      bit en = ($urandom_range(0, 9) != 0);
      bit cv = ($urandom_range(0, 3) == 0);
      bit dn = m_busy ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 9) == 0);
      bit er = ($urandom_range(0, 7) == 0);
      step(en, cv, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 15)),
           ($urandom_range(0, 19) == 0), int'($urandom_range(0, 65535)),
           1'($urandom), dn, er);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule